// File: doc/BRIEF.md
# Real-Time Clock with Coherent Two-Register Read and Seconds Alarms

This block keeps wall-clock time as a free-running 32-bit seconds count and a millisecond count. Both advance from a slow tick enable, which is nominally 32 kHz and arrives in the fast bus clock domain. The counters sit on the counting side. Every eighth tick opens a short busy window. At the end of that window the counter values are posted to a bus-side copy, and software reads that copy through a simple single-cycle register bus.

Software obtains a coherent time sample by reading the milliseconds register first and the shadow seconds register second. The milliseconds read captures the bus-side seconds into the shadow register, so the pair always belongs together. A write to the time register or to an alarm register that lands inside a busy window is parked in a one-entry holding slot. It takes effect on the first cycle after the window closes.

Two seconds alarms compare against the live seconds count. Each alarm raises a sticky status bit, and the interrupt line reports any status bit whose enable bit is set.

Top module: `rtc_shadow_core`

## Requirements
- R1: After reset every readable register reads 0, and the interrupt output is low.
- R2: The milliseconds count (read at 0x10) steps once per TICKS_PER_MS ticks, runs from 0 to MS_PER_SEC-1, and wraps to 0. The seconds count steps by one at each wrap.
- R3: The tick that completes each group of TICKS_PER_UPDATE ticks opens a busy window, during which bit 0 of the register at 0x04 reads 1 for BUSY_CYCLES bus clocks. When the window ends, the bus-side seconds (0x08) and milliseconds (0x10) take the counter values.
- R4: A read of 0x10 copies the bus-side seconds into the shadow register at 0x0C. No other access changes the shadow register.
- R5: A write to 0x08 outside a busy window sets the seconds count, and the new value reads back from the next cycle on.
- R6: A write to 0x08, 0x14 or 0x18 during a busy window is held. Reads during that window return the old value. The held write is applied on the first cycle after the window ends.
- R7: Status bit 0 (alarm at 0x14) or bit 1 (alarm at 0x18) sets when the seconds count becomes equal to that alarm's nonzero value, whatever the enable bits hold. An alarm value of 0 never sets its bit.
- R8: The status register at 0x2C is write-one-to-clear. Zero bits in the written data leave their status bits unchanged. A status bit that sets in the same cycle as its clear stays set.
- R9: The enable register at 0x28 holds 5 bits in the same layout as status: bit 0 alarm 0, bit 1 alarm 1, bit 2 milliseconds alarm, bits 3 and 4 countdown alarms (bits 2 to 4 have no source here and stay 0 in status). The interrupt output is high exactly when some status bit and its enable bit are both 1.
- R10: A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable per slow-clock tick |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq | output | 1 | Level interrupt request |

## Verification
Two events can fall in the same clock edge: an alarm match setting its status bit, and a software write-one-to-clear aimed at that same bit. The bench provokes the collision by writing an alarm value, writing the seconds register to that value on the next cycle, and issuing the status clear on the cycle right after. That places the clear on exactly the edge where the match registers. The status read that follows must still show the bit set. A second clear one access later must then remove it, which shows the first clear was overridden by the set and not simply lost.

// File: rtl/rtc_shadow_core.sv
module rtc_shadow_core #(
  parameter int TICKS_PER_MS     = 4,
  parameter int MS_PER_SEC       = 1000,
  parameter int TICKS_PER_UPDATE = 8,
  parameter int BUSY_CYCLES      = 4,
  parameter int AW               = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int DW  = $clog2(TICKS_PER_MS + 1);
  localparam int MSW = $clog2(MS_PER_SEC);
  localparam int UW  = $clog2(TICKS_PER_UPDATE + 1);
  localparam int BW  = $clog2(BUSY_CYCLES + 1);
  localparam int NI  = 5;

  localparam logic [AW-1:0] A_BUSY = AW'(8'h04);
  localparam logic [AW-1:0] A_SEC  = AW'(8'h08);
  localparam logic [AW-1:0] A_SHD  = AW'(8'h0C);
  localparam logic [AW-1:0] A_MS   = AW'(8'h10);
  localparam logic [AW-1:0] A_AL0  = AW'(8'h14);
  localparam logic [AW-1:0] A_AL1  = AW'(8'h18);
  localparam logic [AW-1:0] A_MSK  = AW'(8'h28);
  localparam logic [AW-1:0] A_STS  = AW'(8'h2C);

  logic [DW-1:0]  div_q;
  logic [MSW-1:0] ms_q, ms_bus;
  logic [31:0]    sec_q, sec_bus, shadow;
  logic [31:0]    alm0, alm1;
  logic [UW-1:0]  upd_q;
  logic [BW-1:0]  busy_q;
  logic [NI-1:0]  mask, stat;
  logic           pend_v;
  logic [AW-1:0]  pend_a;
  logic [31:0]    pend_d;
  logic           m0_q, m1_q;

  wire busy     = busy_q != '0;
  wire rd       = bus_sel & ~bus_wr;
  wire wr       = bus_sel & bus_wr;
  wire timed    = (bus_addr == A_SEC) | (bus_addr == A_AL0) | (bus_addr == A_AL1);
  wire wr_now   = wr & timed & ~busy;
  wire wr_hold  = wr & timed & busy;
  wire pend_go  = pend_v & ~busy;
  wire ms_step  = tick & (div_q == DW'(TICKS_PER_MS - 1));
  wire sec_step = ms_step & (ms_q == MSW'(MS_PER_SEC - 1));
  wire win_go   = tick & (upd_q == UW'(TICKS_PER_UPDATE - 1));
  wire copy     = busy_q == BW'(1);
  wire m0       = (alm0 != '0) & (sec_q == alm0);
  wire m1       = (alm1 != '0) & (sec_q == alm1);

  wire [NI-1:0] set = {3'b000, m1 & ~m1_q, m0 & ~m0_q};
  wire [NI-1:0] clr = (wr && bus_addr == A_STS) ? bus_wdata[NI-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ms_q   <= '0;
      upd_q  <= '0;
      busy_q <= '0;
    end else begin
      if (tick) begin
        div_q <= ms_step ? '0 : div_q + DW'(1);
        upd_q <= win_go ? '0 : upd_q + UW'(1);
      end
      if (ms_step) ms_q <= sec_step ? '0 : ms_q + MSW'(1);
      if (win_go)    busy_q <= BW'(BUSY_CYCLES);
      else if (busy) busy_q <= busy_q - BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q   <= '0;
      sec_bus <= '0;
      ms_bus  <= '0;
      alm0    <= '0;
      alm1    <= '0;
    end else begin
      if (sec_step) sec_q <= sec_q + 32'd1;
      if (copy) begin
        sec_bus <= sec_q;
        ms_bus  <= ms_q;
      end
      if (pend_go) begin
        if (pend_a == A_SEC) begin
          sec_q   <= pend_d;
          sec_bus <= pend_d;
        end
        if (pend_a == A_AL0) alm0 <= pend_d;
        if (pend_a == A_AL1) alm1 <= pend_d;
      end
      if (wr_now) begin
        if (bus_addr == A_SEC) begin
          sec_q   <= bus_wdata;
          sec_bus <= bus_wdata;
        end
        if (bus_addr == A_AL0) alm0 <= bus_wdata;
        if (bus_addr == A_AL1) alm1 <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_d <= '0;
    end else if (wr_hold) begin
      pend_v <= 1'b1;
      pend_a <= bus_addr;
      pend_d <= bus_wdata;
    end else if (pend_go) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      mask   <= '0;
      stat   <= '0;
      m0_q   <= 1'b0;
      m1_q   <= 1'b0;
    end else begin
      if (rd && bus_addr == A_MS) shadow <= sec_bus;
      if (wr && bus_addr == A_MSK) mask <= bus_wdata[NI-1:0];
      stat <= (stat & ~clr) | set;
      m0_q <= m0;
      m1_q <= m1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_BUSY:  bus_rdata = {31'd0, busy};
        A_SEC:   bus_rdata = sec_bus;
        A_SHD:   bus_rdata = shadow;
        A_MS:    bus_rdata = 32'(ms_bus);
        A_AL0:   bus_rdata = alm0;
        A_AL1:   bus_rdata = alm1;
        A_MSK:   bus_rdata = 32'(mask);
        A_STS:   bus_rdata = 32'(stat);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = |(stat & mask);
endmodule

// File: rtl/rtc_shadow_core_chk.sv
module rtc_shadow_core_chk #(
  parameter int MS_PER_SEC = 1000,
  parameter int AW         = 6
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tick,
  input logic                          bus_sel,
  input logic                          bus_wr,
  input logic [AW-1:0]                 bus_addr,
  input logic                          irq,
  input logic                          busy,
  input logic [$clog2(MS_PER_SEC)-1:0] ms_q,
  input logic [31:0]                   shadow,
  input logic [31:0]                   alm0,
  input logic [4:0]                    stat,
  input logic [4:0]                    mask
);
  localparam logic [AW-1:0] A_MS  = AW'(8'h10);
  localparam logic [AW-1:0] A_AL0 = AW'(8'h14);

  a_r2_ms_range: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q < ($clog2(MS_PER_SEC))'(MS_PER_SEC));

  a_r3_window_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick));

  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr && bus_addr == A_MS) |=> $stable(shadow));

  a_r6_alarm_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_sel && bus_wr && bus_addr == A_AL0) |=> $stable(alm0));

  a_r7_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $past(alm0) != 32'd0);

  a_r9_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 5'd0) |-> !irq);
endmodule

bind rtc_shadow_core rtc_shadow_core_chk #(.MS_PER_SEC(MS_PER_SEC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .irq(irq), .busy(busy), .ms_q(ms_q), .shadow(shadow),
  .alm0(alm0), .stat(stat), .mask(mask)
);

// File: tb/rtc_shadow_core_bench.sv
module rtc_shadow_core_bench;
  localparam int TPM = 4;
  localparam int MSPS = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int m_div = 0, m_ms = 0;
  logic [31:0] m_sec = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [5:0]  adr_q[$];

  rtc_shadow_core #(.TICKS_PER_MS(TPM), .MS_PER_SEC(MSPS)) u_rtc_shadow_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (bus_sel && !bus_wr) begin
      if (exp_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL monitor: read with no expectation, actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        logic [5:0] a;
        e = exp_q.pop_front(); t = tag_q.pop_front(); a = adr_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: addr %h actual %h expected %h", t, a, bus_rdata, e);
        end
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == 6'h08) m_sec = d;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t); adr_q.push_back(a);
  endtask

  task automatic tick_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
      m_div++;
      if (m_div == TPM) begin
        m_div = 0; m_ms++;
        if (m_ms == MSPS) begin m_ms = 0; m_sec++; end
      end
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual %0b expected %0b", t, irq, e);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(6'h08, 0, "R1 seconds");
    rd(6'h10, 0, "R1 millis");
    rd(6'h0C, 0, "R1 shadow");
    rd(6'h2C, 0, "R1 status");
    rd(6'h28, 0, "R1 enable");
    rd(6'h04, 0, "R1 busy");
    idle();
    chk_irq(1'b0, "R1 irq");

    // R2 R3 first update window posts counters
    tick_burst(8);
    settle();
    rd(6'h10, 32'(m_ms), "R2 millis after 8 ticks");
    rd(6'h08, m_sec, "R3 seconds posted");
    idle();

    // R3 R6 write inside busy window is held
    tick_burst(8);
    wr(6'h14, 33);
    rd(6'h14, 0, "R6 old alarm during window");
    rd(6'h04, 1, "R3 busy bit set in window");
    idle();
    settle();
    rd(6'h04, 0, "R3 busy bit clear after window");
    rd(6'h14, 33, "R6 held alarm applied");
    rd(6'h10, 32'(m_ms), "R3 millis posted");
    idle();

    // R4 R5 shadow latch
    wr(6'h08, 7);
    rd(6'h0C, 0, "R4 shadow unchanged before millis read");
    rd(6'h08, 7, "R5 seconds write");
    rd(6'h10, 32'(m_ms), "R4 millis read");
    rd(6'h0C, 7, "R4 shadow latched");
    idle();

    // R7 R8 R9 alarm 0
    wr(6'h08, 33);
    idle();
    rd(6'h2C, 1, "R7 alarm0 status while disabled in enable");
    idle();
    chk_irq(1'b0, "R9 irq masked");
    wr(6'h28, 1);
    idle();
    chk_irq(1'b1, "R9 irq enabled");
    wr(6'h2C, 0);
    rd(6'h2C, 1, "R8 zero write keeps status");
    wr(6'h2C, 32'hFFFF_FFFF);
    rd(6'h2C, 0, "R8 all-ones clear");
    idle();
    chk_irq(1'b0, "R9 irq after clear");

    // R7 zero alarm disabled
    wr(6'h14, 0);
    wr(6'h08, 0);
    idle();
    rd(6'h2C, 0, "R7 zero alarm never fires");
    idle();

    // R8 set wins over same-cycle clear
    wr(6'h14, 20);
    wr(6'h08, 20);
    wr(6'h2C, 1);
    rd(6'h2C, 1, "R8 set wins over clear");
    wr(6'h2C, 1);
    rd(6'h2C, 0, "R8 later clear");
    idle();

    // R2 R7 R9 seconds wrap fires alarm 1
    wr(6'h08, 7);
    wr(6'h18, 8);
    wr(6'h28, 2);
    idle();
    tick_burst(4000);
    settle();
    rd(6'h10, 32'(m_ms), "R2 millis wrapped");
    rd(6'h08, m_sec, "R2 seconds incremented on wrap");
    rd(6'h2C, 2, "R7 alarm1 fired on count");
    rd(6'h28, 2, "R9 enable readback");
    idle();
    chk_irq(1'b1, "R9 irq from alarm1");

    // R10 unmapped
    rd(6'h20, 0, "R10 unmapped read");
    idle();
    repeat (2) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule